// File: doc/BRIEF.md
# Escape-Gated Alternate Instruction Decoder

This front-end decode stage sits on a byte-serial instruction stream. In normal mode it forwards ordinary bytes to the downstream decoder. It watches for a two-byte escape opcode, 0x0F then 0x3F. When the mode-enable bit is clear, the escape raises an invalid-opcode fault. When the bit is set, the escape issues a near branch to the target held in the EAX input and switches the stage into alternate mode.

In alternate mode every instruction arrives inside a fixed load-effective-address wrapper. The stage checks the wrapper bytes, discards them, and assembles the four displacement bytes into a 32-bit alternate instruction word. A 16-bit code segment needs an extra address-size prefix in front of each wrapper. A word whose top byte equals a parameterised return opcode sends the stage back to normal mode and presents the word's low 24 bits as the return target.

The stage is a single state machine with these states:
- NORM: normal pass-through.
- HOLD: a 0x0F is being held while the stage waits to see whether the escape follows.
- ALT_START, ALT_OPC, ALT_MOD and ALT_SIB: the wrapper bytes in their expected order.
- ALT_DISP: the four payload bytes are being collected.

The transitions are:
- NORM→HOLD on 0x0F.
- HOLD→HOLD on another 0x0F.
- HOLD→NORM on any other byte, or on an escape while the enable bit is 0.
- HOLD→ALT_START on an escape while the enable bit is 1.
- ALT_START→ALT_OPC on 0x67 when the segment is 16-bit, or ALT_START→ALT_MOD on 0x8D when it is 32-bit.
- ALT_OPC→ALT_MOD on 0x8D.
- ALT_MOD→ALT_SIB on 0x84.
- ALT_SIB→ALT_DISP on 0x00.
- ALT_DISP→ALT_START after the fourth payload byte of an ordinary word.
- ALT_DISP→NORM after the fourth payload byte of a return word.
- Any wrapper state→ALT_START on a byte that breaks the pattern.

Top module: `alt_escape_decoder`

## Requirements
- R1: A synchronous reset puts the stage in normal mode with no held 0x0F and no partial wrapper, clears every output, and makes `alt_mode` 0. A 0x3F that follows the reset is forwarded as an ordinary byte.
- R2: In normal mode, an accepted byte other than 0x0F appears on `pass_data[7:0]` with `pass_cnt`=1 in the cycle after it is accepted.
- R3: A 0x0F is held. If the next byte is neither 0x3F nor 0x0F, the stage emits both bytes with `pass_cnt`=2, putting 0x0F in `pass_data[7:0]` and the new byte in `pass_data[15:8]`. A second 0x0F emits one 0x0F and keeps the newer one held.
- R4: When 0x0F 0x3F arrives with `mode_en`=0, `ud_fault` pulses for one cycle, no byte is forwarded, and the stage stays in normal mode.
- R5: When 0x0F 0x3F arrives with `mode_en`=1, `br_vld` pulses for one cycle and `br_target` equals the `eax_in` value sampled with the 0x3F. From then on `alt_mode` is 1.
- R6: When `cs16`=0, an alternate instruction is the bytes 0x8D 0x84 0x00 followed by four payload bytes. `word_vld` pulses for one cycle after the fourth payload byte, and `word_out` holds the payload little-endian, with the first payload byte in bits 7:0.
- R7: When `cs16`=1, each wrapper must begin with 0x67. After that prefix the decode follows R6.
- R8: In alternate mode, a byte that breaks the expected wrapper pattern pulses `wrap_fault`, and the wrapper match restarts at its first byte. This includes a missing 0x67 when `cs16`=1 and an unexpected 0x67 when `cs16`=0. The stage stays in alternate mode.
- R9: A completed word whose bits 31:24 equal `RET_OPCODE` (default 0xA5) pulses `ret_vld` together with `word_vld`. It puts bits 23:0 on `ret_target` and returns the stage to normal mode.
- R10: `mode_en` affects only the escape decision. Its value has no effect on wrapper decoding in alternate mode.
- R11: A cycle with `byte_vld`=0 changes no state and leaves every pulse output and `pass_cnt` at 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_en | input | 1 | Alternate-mode enable control bit |
| cs16 | input | 1 | Code segment is 16-bit |
| eax_in | input | 32 | Branch target register value |
| byte_vld | input | 1 | Instruction byte valid |
| byte_in | input | 8 | Instruction byte |
| pass_cnt | output | 2 | Number of bytes forwarded this cycle |
| pass_data | output | 16 | Forwarded bytes, the first in bits 7:0 |
| ud_fault | output | 1 | Invalid-opcode fault pulse |
| br_vld | output | 1 | Escape branch pulse |
| br_target | output | 32 | Escape branch target |
| alt_mode | output | 1 | Alternate mode active |
| word_vld | output | 1 | Alternate word valid pulse |
| word_out | output | 32 | Alternate instruction word |
| wrap_fault | output | 1 | Malformed-wrapper fault pulse |
| ret_vld | output | 1 | Return-to-normal pulse |
| ret_target | output | 24 | Return target from the return word |

## Verification
The assertions assume `eax_in` is stable enough to be sampled together with the escape's second byte. They also assume `cs16` does not change partway through a wrapper; the stage reads it only at the wrapper's first byte. The stimulus drives all inputs on the falling edge, changes `cs16` only on instruction boundaries, and holds `rst` low except in the dedicated reset tests. Those tests deliberately apply reset while a 0x0F is held and while a wrapper is partly matched.

// File: rtl/altdec_pkg.sv
package altdec_pkg;

    typedef enum logic [2:0] {
        ST_NORM,
        ST_HOLD,
        ST_ALT_START,
        ST_ALT_OPC,
        ST_ALT_MOD,
        ST_ALT_SIB,
        ST_ALT_DISP
    } dec_state_t;

    localparam logic [7:0] ESC_LEAD  = 8'h0F;
    localparam logic [7:0] ESC_TAIL  = 8'h3F;
    localparam logic [7:0] WRAP_ASZ  = 8'h67;
    localparam logic [7:0] WRAP_OPC  = 8'h8D;
    localparam logic [7:0] WRAP_MOD  = 8'h84;
    localparam logic [7:0] WRAP_SIB  = 8'h00;

    function automatic logic is_alt(input dec_state_t s);
        return (s != ST_NORM) && (s != ST_HOLD);
    endfunction

endpackage

// File: rtl/altdec_escape.sv
module altdec_escape
    import altdec_pkg::*;
(
    input  dec_state_t  state,
    input  logic [7:0]  byte_in,
    input  logic        mode_en,
    output dec_state_t  nxt,
    output logic [1:0]  pcnt,
    output logic [15:0] pdat,
    output logic        ud,
    output logic        br
);

    always_comb begin
        nxt  = ST_NORM;
        pcnt = 2'd0;
        pdat = 16'h0000;
        ud   = 1'b0;
        br   = 1'b0;
        if (state == ST_HOLD) begin
            if (byte_in == ESC_TAIL) begin
                if (mode_en) begin
                    br  = 1'b1;
                    nxt = ST_ALT_START;
                end else begin
                    ud  = 1'b1;
                end
            end else if (byte_in == ESC_LEAD) begin
                pcnt = 2'd1;
                pdat = {8'h00, ESC_LEAD};
                nxt  = ST_HOLD;
            end else begin
                pcnt = 2'd2;
                pdat = {byte_in, ESC_LEAD};
            end
        end else begin
            if (byte_in == ESC_LEAD) begin
                nxt = ST_HOLD;
            end else begin
                pcnt = 2'd1;
                pdat = {8'h00, byte_in};
            end
        end
    end

endmodule

// File: rtl/altdec_wrap_check.sv
module altdec_wrap_check
    import altdec_pkg::*;
(
    input  dec_state_t state,
    input  logic       cs16,
    input  logic [7:0] byte_in,
    output logic       ok,
    output dec_state_t nxt
);

    always_comb begin
        ok  = 1'b0;
        nxt = ST_ALT_START;
        unique case (state)
            ST_ALT_START: begin
                if (cs16) begin
                    ok  = (byte_in == WRAP_ASZ);
                    nxt = ok ? ST_ALT_OPC : ST_ALT_START;
                end else begin
                    ok  = (byte_in == WRAP_OPC);
                    nxt = ok ? ST_ALT_MOD : ST_ALT_START;
                end
            end
            ST_ALT_OPC: begin
                ok  = (byte_in == WRAP_OPC);
                nxt = ok ? ST_ALT_MOD : ST_ALT_START;
            end
            ST_ALT_MOD: begin
                ok  = (byte_in == WRAP_MOD);
                nxt = ok ? ST_ALT_SIB : ST_ALT_START;
            end
            ST_ALT_SIB: begin
                ok  = (byte_in == WRAP_SIB);
                nxt = ok ? ST_ALT_DISP : ST_ALT_START;
            end
            ST_ALT_DISP: begin
                ok  = 1'b1;
                nxt = ST_ALT_DISP;
            end
            default: begin
                ok  = 1'b0;
                nxt = ST_ALT_START;
            end
        endcase
    end

endmodule

// File: rtl/altdec_payload.sv
module altdec_payload #(
    parameter int PAY_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [7:0]             byte_in,
    output logic                   last,
    output logic [PAY_BYTES*8-1:0] word
);

    localparam int W  = PAY_BYTES * 8;
    localparam int CW = (PAY_BYTES > 1) ? $clog2(PAY_BYTES) : 1;

    logic [W-1:0]  acc;
    logic [CW-1:0] cnt;

    assign last = load && (cnt == CW'(PAY_BYTES - 1));
    assign word = {byte_in, acc[W-1:8]};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            cnt <= '0;
        end else if (load) begin
            acc <= word;
            cnt <= last ? '0 : cnt + CW'(1);
        end
    end

    // R6: after the final payload byte the collection restarts from zero
    assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (rst)
        last |=> (cnt == '0));

    // R6: count never passes the payload length
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(PAY_BYTES - 1));

endmodule

// File: rtl/alt_escape_decoder.sv
module alt_escape_decoder
    import altdec_pkg::*;
#(
    parameter logic [7:0] RET_OPCODE = 8'hA5,
    parameter int         PAY_BYTES  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_en,
    input  logic        cs16,
    input  logic [31:0] eax_in,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    output logic [1:0]  pass_cnt,
    output logic [15:0] pass_data,
    output logic        ud_fault,
    output logic        br_vld,
    output logic [31:0] br_target,
    output logic        alt_mode,
    output logic        word_vld,
    output logic [31:0] word_out,
    output logic        wrap_fault,
    output logic        ret_vld,
    output logic [23:0] ret_target
);

    localparam int W = PAY_BYTES * 8;

    dec_state_t state, state_nxt;
    dec_state_t esc_nxt, wr_nxt;
    logic [1:0]  esc_pcnt;
    logic [15:0] esc_pdat;
    logic        esc_ud, esc_br;
    logic        wr_ok;
    logic        pay_load, pay_last;
    logic [W-1:0] pay_word;
    logic        in_alt, is_ret;

    assign in_alt   = is_alt(state);
    assign pay_load = byte_vld && (state == ST_ALT_DISP);
    assign is_ret   = (pay_word[W-1 -: 8] == RET_OPCODE);
    assign alt_mode = in_alt;

    altdec_escape u_esc (
        .state   (state),
        .byte_in (byte_in),
        .mode_en (mode_en),
        .nxt     (esc_nxt),
        .pcnt    (esc_pcnt),
        .pdat    (esc_pdat),
        .ud      (esc_ud),
        .br      (esc_br)
    );

    altdec_wrap_check u_wrap (
        .state   (state),
        .cs16    (cs16),
        .byte_in (byte_in),
        .ok      (wr_ok),
        .nxt     (wr_nxt)
    );

    altdec_payload #(.PAY_BYTES(PAY_BYTES)) u_pay (
        .clk     (clk),
        .rst     (rst),
        .load    (pay_load),
        .byte_in (byte_in),
        .last    (pay_last),
        .word    (pay_word)
    );

    always_comb begin
        state_nxt = state;
        if (byte_vld) begin
            unique case (state)
                ST_NORM, ST_HOLD: state_nxt = esc_nxt;
                ST_ALT_START, ST_ALT_OPC, ST_ALT_MOD, ST_ALT_SIB:
                    state_nxt = wr_nxt;
                ST_ALT_DISP: begin
                    if (pay_last) state_nxt = is_ret ? ST_NORM : ST_ALT_START;
                    else          state_nxt = ST_ALT_DISP;
                end
                default: state_nxt = ST_NORM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_NORM;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_cnt   <= 2'd0;
            pass_data  <= 16'h0000;
            ud_fault   <= 1'b0;
            br_vld     <= 1'b0;
            br_target  <= 32'h0;
            word_vld   <= 1'b0;
            word_out   <= 32'h0;
            wrap_fault <= 1'b0;
            ret_vld    <= 1'b0;
            ret_target <= 24'h0;
        end else begin
            pass_cnt   <= 2'd0;
            ud_fault   <= 1'b0;
            br_vld     <= 1'b0;
            word_vld   <= 1'b0;
            wrap_fault <= 1'b0;
            ret_vld    <= 1'b0;
            if (byte_vld) begin
                if (!in_alt) begin
                    pass_cnt <= esc_pcnt;
                    if (esc_pcnt != 2'd0) pass_data <= esc_pdat;
                    ud_fault <= esc_ud;
                    br_vld   <= esc_br;
                    if (esc_br) br_target <= eax_in;
                end else begin
                    wrap_fault <= !wr_ok;
                    if (pay_last) begin
                        word_vld <= 1'b1;
                        word_out <= pay_word[31:0];
                        if (is_ret) begin
                            ret_vld    <= 1'b1;
                            ret_target <= pay_word[23:0];
                        end
                    end
                end
            end
        end
    end

    // R4: a fault never coincides with entering alternate mode
    assert_ud_no_mode_R4: assert property (@(posedge clk) disable iff (rst)
        ud_fault |-> !alt_mode);

    // R5: the branch always lands in alternate mode with the sampled target
    assert_br_enters_alt_R5: assert property (@(posedge clk) disable iff (rst)
        br_vld |-> (alt_mode && br_target == $past(eax_in)));

    // R9: a return word exits the mode and is also a valid word
    assert_ret_exit_R9: assert property (@(posedge clk) disable iff (rst)
        ret_vld |-> (!alt_mode && word_vld));

    // R2: nothing is forwarded while the stage is in alternate mode
    assert_pass_normal_R2: assert property (@(posedge clk) disable iff (rst)
        (pass_cnt != 2'd0) |-> !$past(alt_mode));

    // R8: fault, branch and word events are mutually exclusive
    assert_events_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ud_fault, br_vld, wrap_fault, word_vld}));

    // R11: an idle cycle leaves the outputs quiet and the mode unchanged
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> (pass_cnt == 2'd0 && !word_vld && !wrap_fault &&
                       !br_vld && !ud_fault && $stable(alt_mode)));

endmodule

// File: tb/tb_alt_escape_decoder.sv
`timescale 1ns/100ps
module tb_alt_escape_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_en = 1'b0;
    logic        cs16 = 1'b0;
    logic [31:0] eax_in = 32'h0040_1000;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [1:0]  pass_cnt;
    logic [15:0] pass_data;
    logic        ud_fault, br_vld, alt_mode, word_vld, wrap_fault, ret_vld;
    logic [31:0] br_target, word_out;
    logic [23:0] ret_target;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alt_escape_decoder dut (
        .clk(clk), .rst(rst), .mode_en(mode_en), .cs16(cs16), .eax_in(eax_in),
        .byte_vld(byte_vld), .byte_in(byte_in), .pass_cnt(pass_cnt),
        .pass_data(pass_data), .ud_fault(ud_fault), .br_vld(br_vld),
        .br_target(br_target), .alt_mode(alt_mode), .word_vld(word_vld),
        .word_out(word_out), .wrap_fault(wrap_fault), .ret_vld(ret_vld),
        .ret_target(ret_target)
    );

    // row: {en, cs16, byte, pass_cnt, pass_data, ud,br,alt,wv,wf,rv, word}
    localparam int NV = 46;
    localparam logic [65:0] TBL [0:NV-1] = '{
        {1'b1,1'b0,8'h41, 2'd1,16'h0041, 6'b000000, 32'h0},        // R2
        {1'b1,1'b0,8'h0F, 2'd0,16'h0000, 6'b000000, 32'h0},        // R3
        {1'b1,1'b0,8'h22, 2'd2,16'h220F, 6'b000000, 32'h0},        // R3
        {1'b1,1'b0,8'h0F, 2'd0,16'h0000, 6'b000000, 32'h0},
        {1'b1,1'b0,8'h0F, 2'd1,16'h000F, 6'b000000, 32'h0},        // R3
        {1'b0,1'b0,8'h3F, 2'd0,16'h0000, 6'b100000, 32'h0},        // R4
        {1'b1,1'b0,8'h0F, 2'd0,16'h0000, 6'b000000, 32'h0},
        {1'b1,1'b0,8'h3F, 2'd0,16'h0000, 6'b011000, 32'h0},        // R5
        {1'b0,1'b0,8'h8D, 2'd0,16'h0000, 6'b001000, 32'h0},        // R10
        {1'b0,1'b0,8'h84, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h00, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h78, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h56, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h34, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h12, 2'd0,16'h0000, 6'b001100, 32'h12345678}, // R6
        {1'b1,1'b0,8'h67, 2'd0,16'h0000, 6'b001010, 32'h0},        // R8
        {1'b1,1'b0,8'h8D, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h84, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h01, 2'd0,16'h0000, 6'b001010, 32'h0},        // R8
        {1'b1,1'b0,8'h8D, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h84, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h00, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h00, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h00, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'h10, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b0,8'hA5, 2'd0,16'h0000, 6'b000101, 32'hA5100000}, // R9
        {1'b1,1'b0,8'h0F, 2'd0,16'h0000, 6'b000000, 32'h0},
        {1'b1,1'b0,8'h3F, 2'd0,16'h0000, 6'b011000, 32'h0},        // R5
        {1'b1,1'b1,8'h67, 2'd0,16'h0000, 6'b001000, 32'h0},        // R7
        {1'b1,1'b1,8'h8D, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'h84, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'h00, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'hEF, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'hBE, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'hAD, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'hDE, 2'd0,16'h0000, 6'b001100, 32'hDEADBEEF}, // R7
        {1'b1,1'b1,8'h8D, 2'd0,16'h0000, 6'b001010, 32'h0},        // R8
        {1'b1,1'b1,8'h67, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'h8D, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'h84, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'h00, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'h01, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'h02, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'h03, 2'd0,16'h0000, 6'b001000, 32'h0},
        {1'b1,1'b1,8'hA5, 2'd0,16'h0000, 6'b000101, 32'hA5030201}, // R9
        {1'b1,1'b0,8'h3F, 2'd1,16'h003F, 6'b000000, 32'h0}         // R2
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic e, input logic c, input logic [7:0] b);
        @(negedge clk);
        mode_en = e; cs16 = c; byte_vld = 1'b1; byte_in = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        byte_vld = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; byte_vld = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [65:0] observe();
        logic [15:0] pd;
        logic [31:0] w;
        pd = (pass_cnt != 2'd0) ? pass_data : 16'h0;
        w  = word_vld ? word_out : 32'h0;
        return {10'h0, pass_cnt, pd, ud_fault, br_vld, alt_mode,
                word_vld, wrap_fault, ret_vld, w};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "reset outputs", {alt_mode, pass_cnt, ud_fault, br_vld,
            word_vld, wrap_fault, ret_vld}, 64'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [65:0] row;
            logic [65:0] act;
            row = TBL[i];
            send(row[65], row[64], row[63:56]);
            act = observe();
            checks++;
            if (act[55:0] !== row[55:0]) begin
                fails++;
                $display("FAIL R2-R10 table row %0d actual=%h expected=%h",
                         i, act[55:0], row[55:0]);
            end
            if (row[36])   // expected branch
                chk("R5", "br_target", {32'h0, br_target}, {32'h0, eax_in});
        end

        // R11: idle cycle leaves outputs quiet
        idle();
        chk("R11", "idle outputs", {pass_cnt, ud_fault, br_vld, word_vld,
            wrap_fault, ret_vld, alt_mode}, 64'h0);

        // R9: return target and br_target with a new EAX
        eax_in = 32'hCAFE_0000;
        send(1'b1, 1'b0, 8'h0F);
        send(1'b1, 1'b0, 8'h3F);
        chk("R5", "br_target new eax", {32'h0, br_target}, 64'hCAFE0000);
        send(1'b1, 1'b0, 8'h8D);
        send(1'b1, 1'b0, 8'h84);
        send(1'b1, 1'b0, 8'h00);
        send(1'b1, 1'b0, 8'hEF);
        send(1'b1, 1'b0, 8'hCD);
        send(1'b1, 1'b0, 8'hAB);
        send(1'b1, 1'b0, 8'hA5);
        chk("R9", "ret_target", {40'h0, ret_target}, 64'hABCDEF);
        chk("R9", "ret exits mode", {63'h0, alt_mode}, 64'h0);

        // R1: reset while 0x0F held drops the pending escape
        send(1'b1, 1'b0, 8'h0F);
        do_reset();
        send(1'b1, 1'b0, 8'h3F);
        chk("R1", "held 0F cleared", {pass_cnt, pass_data, br_vld, alt_mode},
            {2'd1, 16'h003F, 1'b0, 1'b0});

        // R1: reset mid-wrapper returns to normal mode
        send(1'b1, 1'b0, 8'h0F);
        send(1'b1, 1'b0, 8'h3F);
        send(1'b1, 1'b0, 8'h8D);
        do_reset();
        #1;
        chk("R1", "alt cleared by reset", {63'h0, alt_mode}, 64'h0);
        send(1'b1, 1'b0, 8'h41);
        chk("R1", "normal after reset", {pass_cnt, pass_data},
            {2'd1, 16'h0041});

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule